// File: doc/BRIEF.md
# Periodic Tick and Timer Flag Unit

This block raises a periodic interrupt at one of four rates and keeps the status and mask bits of a small timer subsystem. The tick comes from a free-running divider clocked by the bus-clock enable. The divider is cleared only by reset, so later software writes never shift its phase. A 16-bit free-running counter runs alongside it, and its rollover sets a flag. Two event inputs, driven by an external pulse accumulator, set two more flags.

Software reaches three byte-wide registers over a simple register bus: address 0 is the flag register, address 1 is the mask register, address 2 is the rate select, and address 3 reads as zero. Flags are cleared by writing ones. The single interrupt output is a level that stays high while any enabled flag is set. With every mask clear, the flags still set and can be polled.

Top module: `tick_flag_unit`

## Requirements
- R1: Reset (rst_n low) clears all flags, all mask bits, the rate select, the rollover counter and the divider. After reset, addresses 0, 1 and 2 read 0x00 and irq is low.
- R2: The rate select sits in bits 1:0 of address 2. With select value s, the periodic-tick flag (bit 6 of address 0) sets once every 2^(DIV_BASE+s) enabled clocks. With the default DIV_BASE=13, the periods run from 8192 to 65536 enabled clocks.
- R3: Writing the rate select never restarts the divider. After a change of select, the next tick stays aligned with the ticks taken before the change.
- R4: The divider and the counter advance only in cycles where clk_en is high.
- R5: The counter-rollover flag (bit 7 of address 0) sets each time the CNT_W-bit counter wraps from all ones to zero, which happens once every 2^CNT_W enabled clocks.
- R6: A high pa_ovf_evt in a cycle sets bit 5 of address 0, and a high pa_edge_evt sets bit 4. The flag is visible in the following cycle.
- R7: Bits 3:0 of addresses 0 and 1 always read 0, and bits 7:2 of address 2 read 0.
- R8: Writing 1 to a bit of address 0 clears that flag. Writing 0 leaves the flag unchanged.
- R9: If a flag's set event and a write-1 clear of the same flag fall in the same cycle, the flag stays set.
- R10: Bits 7:4 of address 1 mask the flags in the same positions. irq is high exactly while some flag and its mask bit are both set.
- R11: Flags set whatever the mask bits hold, so they can be polled with irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Bus-clock enable that advances the divider and the counter |
| addr | input | ADDR_W | Register address: 0 flags, 1 mask, 2 rate select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| pa_ovf_evt | input | 1 | Accumulator overflow event, one cycle per event |
| pa_edge_evt | input | 1 | Accumulator input-edge event, one cycle per event |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DIV_BASE=3 and CNT_W=6. This gives tick periods of 8, 16, 32 and 64 clocks and a counter rollover every 64 clocks. With these values, each of the four rates, several rollovers and a phase check across a select change all fit in a few hundred cycles. Halving clk_en reaches the gating behaviour in the same short window. The pin-level timing is the same as at the default widths, because only the divider and counter lengths change.

// File: rtl/tick_flag_pkg.sv
package tick_flag_pkg;
  // Positions inside the upper nibble of the flag and mask registers
  localparam int FLG_ROLL = 3;  // register bit 7
  localparam int FLG_TICK = 2;  // register bit 6
  localparam int FLG_PAOV = 1;  // register bit 5
  localparam int FLG_PAED = 0;  // register bit 4
  localparam int NFLAG    = 4;
  localparam int DATA_W   = 8;

  typedef logic [NFLAG-1:0] flag_vec_t;

  typedef enum logic [1:0] {
    REG_FLAGS = 2'd0,
    REG_MASK  = 2'd1,
    REG_RATE  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV_BASE = 13,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick_o
);
  localparam int DIV_W = DIV_BASE + (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, span;

  // Bits 0 .. DIV_BASE-1+sel: the chosen bit falls when all of them are ones
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      span[i] = (i < DIV_BASE + int'(rate_sel));
    end
  end

  always_comb begin
    div_d = div_q;
    if (clk_en) div_d = div_q + 1'b1;
  end

  assign tick_o = clk_en && ((div_q & span) == span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/roll_counter.sv
module roll_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  output logic wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clk_en) cnt_d = cnt_q + 1'b1;
  end

  assign wrap_o = clk_en && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import tick_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_i,
  input  logic      flag_wr,
  input  logic      mask_wr,
  input  flag_vec_t wdata_i,
  output flag_vec_t flags_o,
  output flag_vec_t mask_o,
  output logic      irq_o
);
  flag_vec_t flag_q, flag_d, mask_q, mask_d;

  for (genvar b = 0; b < NFLAG; b++) begin : g_bit
    // a set event outranks a write-one clear in the same cycle
    always_comb begin
      flag_d[b] = set_i[b] | (flag_q[b] & ~(flag_wr & wdata_i[b]));
      mask_d[b] = mask_wr ? wdata_i[b] : mask_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[b] <= 1'b0;
        mask_q[b] <= 1'b0;
      end else begin
        flag_q[b] <= flag_d[b];
        mask_q[b] <= mask_d[b];
      end
    end
  end

  assign flags_o = flag_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flag_q & mask_q);
endmodule

// File: rtl/tick_flag_unit.sv
module tick_flag_unit
  import tick_flag_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DIV_BASE = 13,
  parameter int SEL_W    = 2,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pa_ovf_evt,
  input  logic              pa_edge_evt,
  output logic              irq
);
  localparam int LO_W = DATA_W - NFLAG;

  logic       rst_meta_n, rst_sync_n;
  logic [SEL_W-1:0] rate_q, rate_d;
  logic       tick, wrap;
  flag_vec_t  set_vec, flags_q, mask_q;
  logic       sel_flags, sel_mask, sel_rate;
  logic [LO_W-1:0] unused_lo;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign sel_flags = (addr == ADDR_W'(REG_FLAGS));
  assign sel_mask  = (addr == ADDR_W'(REG_MASK));
  assign sel_rate  = (addr == ADDR_W'(REG_RATE));
  assign unused_lo = wr_data[LO_W-1:0];

  always_comb begin
    rate_d = rate_q;
    if (wr_en && sel_rate) rate_d = wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rate_q <= '0;
    else             rate_q <= rate_d;
  end

  tick_divider #(.DIV_BASE(DIV_BASE), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .clk_en(clk_en),
    .rate_sel(rate_q), .tick_o(tick)
  );

  roll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clk_en(clk_en), .wrap_o(wrap)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_ROLL] = wrap;
    set_vec[FLG_TICK] = tick;
    set_vec[FLG_PAOV] = pa_ovf_evt;
    set_vec[FLG_PAED] = pa_edge_evt;
  end

  flag_bank u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_i(set_vec),
    .flag_wr(wr_en && sel_flags), .mask_wr(wr_en && sel_mask),
    .wdata_i(wr_data[DATA_W-1:LO_W]),
    .flags_o(flags_q), .mask_o(mask_q), .irq_o(irq)
  );

  always_comb begin
    rd_data = '0;
    if (sel_flags)     rd_data = {flags_q, {LO_W{1'b0}}};
    else if (sel_mask) rd_data = {mask_q, {LO_W{1'b0}}};
    else if (sel_rate) rd_data = {{(DATA_W-SEL_W){1'b0}}, rate_q};
  end
endmodule

// File: rtl/tick_flag_chk.sv
module tick_flag_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              pa_ovf_evt,
  input logic              pa_edge_evt,
  input logic [3:0]        flags,
  input logic [3:0]        masks,
  input logic              irq
);
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rd_data[3:0] == 4'h0)); // R7
  AST_PA_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pa_ovf_evt |=> flags[1]); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_edge_evt && wr_en && addr == '0 && wr_data[4]) |=> flags[0]); // R9
  AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wr_data[5] && !pa_ovf_evt) |=> !flags[1]); // R8
  AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(wr_en && addr == '0 && wr_data[4])); // R8
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(clk_en)); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (masks == 4'h0) |-> !irq); // R10
  AST_ENABLED_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & masks)) |-> irq); // R10
endmodule

bind tick_flag_unit tick_flag_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .clk_en(clk_en), .addr(addr),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .pa_ovf_evt(pa_ovf_evt), .pa_edge_evt(pa_edge_evt),
  .flags(flags_q), .masks(mask_q), .irq(irq)
);

// File: tb/sim_tick_flag_unit.sv
module sim_tick_flag_unit;
  logic       clk, rst_n, clk_en, wr_en, pa_ovf_evt, pa_edge_evt;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data;
  logic       irq;
  int         cyc, checks, errors;

  tick_flag_unit #(.CNT_W(6), .DIV_BASE(3), .SEL_W(2), .ADDR_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pa_ovf_evt(pa_ovf_evt),
    .pa_edge_evt(pa_edge_evt), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_bit(input int b, output int t);
    logic [7:0] v;
    t = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_read(2'd0, v);
      if (v[b]) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic measure(input int b, output int p);
    int t0, t1;
    bus_write(2'd0, 8'(1 << b));
    wait_bit(b, t0);
    bus_write(2'd0, 8'(1 << b));
    wait_bit(b, t1);
    p = t1 - t0;
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    for (int a = 0; a < 3; a++) begin
      bus_read(2'(a), v);
      check(v == 8'h00, "R1 register after reset", v, 0);
    end
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
  endtask

  task automatic t_rates;
    int p;
    for (int s = 0; s < 4; s++) begin
      bus_write(2'd2, 8'(s));
      measure(6, p);
      check(p == (8 << s), "R2 tick period", p, 8 << s);
    end
  endtask

  task automatic t_phase;
    int t0, t1;
    bus_write(2'd2, 8'd0);
    bus_write(2'd0, 8'h40);
    wait_bit(6, t0);
    bus_write(2'd0, 8'h40);
    @(negedge clk);
    bus_write(2'd2, 8'd1);
    wait_bit(6, t1);
    check(((t1 - t0) % 8) == 0, "R3 tick phase after select change", (t1 - t0) % 8, 0);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    int t0, t1, seen;
    bus_write(2'd2, 8'd0);
    bus_write(2'd0, 8'h40);
    seen = 0; t0 = 0; t1 = 0;
    for (int i = 0; i < 200 && seen < 2; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      clk_en = ~clk_en;
      bus_read(2'd0, v);
      if (v[6]) begin
        if (seen == 0) t0 = cyc; else t1 = cyc;
        seen++;
        addr = 2'd0; wr_data = 8'h40; wr_en = 1'b1;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; clk_en = 1'b1;
    check(seen == 2 && (t1 - t0) == 16, "R4 period with half-rate enable", t1 - t0, 16);
  endtask

  task automatic t_rollover;
    int p;
    measure(7, p);
    check(p == 64, "R5 rollover period", p, 64);
    measure(7, p);
    check(p == 64, "R5 rollover period repeat", p, 64);
  endtask

  task automatic t_pa_events;
    logic [7:0] v;
    bus_write(2'd0, 8'h30);
    @(negedge clk); pa_ovf_evt = 1'b1;
    @(negedge clk); pa_ovf_evt = 1'b0;
    bus_read(2'd0, v);
    check(v[5:4] == 2'b10, "R6 accumulator overflow flag", v[5:4], 2);
    pa_edge_evt = 1'b1;
    @(negedge clk); pa_edge_evt = 1'b0;
    bus_read(2'd0, v);
    check(v[5:4] == 2'b11, "R6 accumulator edge flag", v[5:4], 3);
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    bus_write(2'd0, 8'h0F);
    bus_read(2'd0, v);
    check(v[3:0] == 4'h0, "R7 flag low nibble", v[3:0], 0);
    bus_write(2'd1, 8'h0F);
    bus_read(2'd1, v);
    check(v == 8'h00, "R7 mask low nibble", v, 0);
    bus_write(2'd2, 8'hFE);
    bus_read(2'd2, v);
    check(v == 8'h02, "R7 rate upper bits", v, 2);
    bus_read(2'd3, v);
    check(v == 8'h00, "R7 unused address", v, 0);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    @(negedge clk); pa_edge_evt = 1'b1;
    @(negedge clk); pa_edge_evt = 1'b0;
    bus_write(2'd0, 8'h20);
    bus_read(2'd0, v);
    check(v[5:4] == 2'b01, "R8 one clears only its bit", v[5:4], 1);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, v);
    check(v[4] == 1'b1, "R8 zero write keeps flag", v[4], 1);
    bus_write(2'd0, 8'h10);
    bus_read(2'd0, v);
    check(v[4] == 1'b0, "R8 one write clears flag", v[4], 0);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    @(negedge clk);
    addr = 2'd0; wr_data = 8'h10; wr_en = 1'b1; pa_edge_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pa_edge_evt = 1'b0;
    bus_read(2'd0, v);
    check(v[4] == 1'b1, "R9 set beats clear", v[4], 1);
    bus_write(2'd0, 8'h10);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    bus_write(2'd1, 8'h10);
    check(irq == 1'b0, "R10 irq low with masked flag clear", irq, 0);
    @(negedge clk); pa_edge_evt = 1'b1;
    @(negedge clk); pa_edge_evt = 1'b0;
    check(irq == 1'b1, "R10 irq on enabled flag", irq, 1);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R10 irq level holds", irq, 1);
    bus_write(2'd1, 8'h00);
    bus_read(2'd0, v);
    check(irq == 1'b0 && v[4], "R11 flag polled with mask clear", {irq, v[4]}, 1);
    bus_write(2'd1, 8'h10);
    check(irq == 1'b1, "R10 irq back on remask", irq, 1);
    bus_write(2'd0, 8'h10);
    check(irq == 1'b0, "R10 irq drops on clear", irq, 0);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic t_reset_again;
    logic [7:0] v;
    bus_write(2'd1, 8'hF0);
    bus_write(2'd2, 8'h03);
    @(negedge clk); pa_ovf_evt = 1'b1;
    @(negedge clk); pa_ovf_evt = 1'b0;
    rst_n = 1'b0;
    for (int a = 0; a < 3; a++) begin
      bus_read(2'(a), v);
      check(v == 8'h00, "R1 register cleared by reset", v, 0);
    end
    check(irq == 1'b0, "R1 irq cleared by reset", irq, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; clk_en = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
    pa_ovf_evt = 1'b0; pa_edge_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    clk_en = 1'b1;
    t_rates();
    t_phase();
    t_enable();
    t_rollover();
    t_pa_events();
    t_unimpl();
    t_w1c();
    t_set_wins();
    t_irq();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule